// File: doc/BRIEF.md
# System Tick Down-Counter Timer

A periodic down-counting timer placed next to a processor core and programmed over a small 32-bit register bus. Software loads a reload value, picks whether the counter advances on every core clock or only on cycles where a slower reference tick enable is high, and turns the timer on. Each time the counter steps down to zero it raises a sticky expiry flag and, if enabled, emits a one-cycle interrupt request for the interrupt controller. On the next tick it reloads and the cycle repeats, so the request period is the reload value plus one tick.

Four word registers are visible: control/status, reload, current count and a constant calibration word. The bus is a simple strobe interface: read data and the error response are combinational in the access cycle, and state changes land on the clock edge that ends it. Accesses flagged unprivileged are refused with an error and change nothing.

Top module: `tick_timer`

## Requirements
- R1: After reset, control/status, reload and current count all read 0 and `irq_o` is low.
- R2: Word offsets: 0x0 control/status, 0x4 reload, 0x8 current count, 0xC calibration, which always reads 10000. A read of any other offset returns 0 without error; a write to one changes no register and raises no error.
- R3: A control write stores only write-data bits [2:0]: bit 0 turns the timer on, bit 1 allows interrupt requests, bit 2 picks the tick source (1 = every core clock, 0 = the reference tick enable). Control reads return those three bits plus the expiry flag in bit 16; every other bit reads 0.
- R4: The reload register holds 24 bits; write-data bits [31:24] are dropped and read back as 0.
- R5: With reload N > 0 and the core clock as source, the first expiry comes N+1 ticks after the timer is switched on from a zero count, and later expiries every N+1 ticks.
- R6: With the reference source selected, the counter moves only on cycles where `ref_tick_i` is high, so a reference tick every 3 clocks gives an expiry period of 3(N+1) clocks.
- R7: Only a tick that steps the counter from 1 to 0 is an expiry. It sets the flag and, when bit 1 is set, drives `irq_o` high for exactly one cycle, the cycle after that tick; with bit 1 clear `irq_o` stays low.
- R8: A read of control/status returns the flag and clears it after the access, so a second read shows it clear.
- R9: A write of any data to the current-count register sets the count to 0 and clears the flag without raising the flag or a request; the next tick loads the reload value.
- R10: When an expiry, or a write to the current count, occurs with the reload value at 0, counting stops while the enable bit stays set.
- R11: An access with `priv_i` low drives `err_o` high in that cycle, returns read data 0 and changes no state, including the expiry flag.
- R12: Counting starts only when a control write moves the enable bit from 0 to 1; writing it as 1 while already set does not restart a halted counter, and clearing it freezes the current count.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ref_tick_i | input | 1 | Reference tick enable, one core clock wide per tick |
| addr_i | input | 8 | Byte address of the register access |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| priv_i | input | 1 | Access is privileged |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| err_o | output | 1 | Error response for a refused access |
| irq_o | output | 1 | One-cycle interrupt request on expiry |

## Verification
The bench sweeps reload values 1 to 8 on the core clock and 1 to 4 on a reference tick, timing the first request and the spacing of the next one arithmetically; a design off by one in the reload step would show a period of N or N+2 instead of N+1. It steps a zero reload under a running count, where a design that cleared the enable bit or kept reloading zero would either read back the wrong control word or fire again. It writes the current count mid-run and reads the count on the next two cycles, catching a design that treats that write as an expiry or that misses the reload. It repeats an enable write over a halted counter and issues unprivileged reads of control/status, which a sloppy design would use to restart counting or to clear the flag.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

    // Control/status field positions
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_SRC_BIT  = 2;
    localparam int CTRL_WR_BITS  = 3;
    localparam int CTRL_FLAG_BIT = 16;

    // Word register selected by the address decoder
    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_RELOAD = 2'd1,
        REG_CUR    = 2'd2,
        REG_CALIB  = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/tick_timer_src.sv
// Tick enable generation: core clock or reference tick
module tick_timer_src #(
    parameter bit REF_EN = 1'b1
) (
    input  logic en_i,
    input  logic core_sel_i,
    input  logic ref_tick_i,
    output logic tick_o
);

    generate
        if (REF_EN) begin : g_ref
            assign tick_o = en_i & (core_sel_i | ref_tick_i);
        end else begin : g_core
            logic unused_src;
            assign unused_src = core_sel_i ^ ref_tick_i;
            assign tick_o     = en_i;
        end
    endgenerate

endmodule

// File: rtl/tick_timer_bus.sv
// Register decode, privilege check and read mux
module tick_timer_bus
    import tick_timer_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          CNT_W     = 24,
    parameter logic [31:0] CALIB_VAL = 32'd10000
) (
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic                    rd_en_i,
    input  logic                    wr_en_i,
    input  logic                    priv_i,
    input  logic [CTRL_WR_BITS-1:0] ctrl_i,
    input  logic                    flag_i,
    input  logic [CNT_W-1:0]        reload_i,
    input  logic [CNT_W-1:0]        cnt_i,
    output logic                    wr_ctrl_o,
    output logic                    wr_reload_o,
    output logic                    wr_cur_o,
    output logic                    rd_ctrl_o,
    output logic [DATA_W-1:0]       rdata_o,
    output logic                    err_o
);

    localparam logic [ADDR_W-1:0] OFF_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFF_RELOAD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFF_CUR    = ADDR_W'(8);
    localparam logic [ADDR_W-1:0] OFF_CALIB  = ADDR_W'(12);

    reg_sel_e sel;
    logic     hit;
    logic     wr_ok;
    logic     rd_ok;

    always_comb begin
        hit = 1'b1;
        sel = REG_CTRL;
        case (addr_i)
            OFF_CTRL:   sel = REG_CTRL;
            OFF_RELOAD: sel = REG_RELOAD;
            OFF_CUR:    sel = REG_CUR;
            OFF_CALIB:  sel = REG_CALIB;
            default:    hit = 1'b0;
        endcase
    end

    assign err_o = (rd_en_i | wr_en_i) & ~priv_i;
    assign wr_ok = wr_en_i & priv_i & hit;
    assign rd_ok = rd_en_i & priv_i & hit;

    assign wr_ctrl_o   = wr_ok & (sel == REG_CTRL);
    assign wr_reload_o = wr_ok & (sel == REG_RELOAD);
    assign wr_cur_o    = wr_ok & (sel == REG_CUR);
    assign rd_ctrl_o   = rd_ok & (sel == REG_CTRL);

    always_comb begin
        rdata_o = '0;
        if (rd_ok) begin
            case (sel)
                REG_CTRL: begin
                    rdata_o[CTRL_WR_BITS-1:0] = ctrl_i;
                    rdata_o[CTRL_FLAG_BIT]    = flag_i;
                end
                REG_RELOAD: rdata_o = DATA_W'(reload_i);
                REG_CUR:    rdata_o = DATA_W'(cnt_i);
                default:    rdata_o = DATA_W'(CALIB_VAL);
            endcase
        end
    end

endmodule

// File: rtl/tick_timer_cnt.sv
// Down-counter with reload, run state, sticky flag and request pulse
module tick_timer_cnt #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             clr_i,
    input  logic             flag_clr_i,
    input  logic             ie_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             flag_o,
    output logic             irq_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             flag;
        logic             irq;
    } cnt_st_t;

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_st_t st_d, st_q;
    logic    reload_zero;

    assign reload_zero = (reload_i == '0);

    always_comb begin
        st_d     = st_q;
        st_d.irq = 1'b0;

        if (flag_clr_i) st_d.flag = 1'b0;

        if (stop_i)       st_d.run = 1'b0;
        else if (start_i) st_d.run = 1'b1;

        if (clr_i) begin
            // software write: zero the count, never an expiry
            st_d.cnt  = '0;
            st_d.flag = 1'b0;
            if (reload_zero) st_d.run = 1'b0;
        end else if (st_q.run && tick_i) begin
            if (st_q.cnt == '0) begin
                st_d.cnt = reload_i;
                if (reload_zero) st_d.run = 1'b0;
            end else begin
                st_d.cnt = st_q.cnt - ONE;
                if (st_q.cnt == ONE) begin
                    // expiry: a new event outranks a same-cycle flag read
                    st_d.flag = 1'b1;
                    st_d.irq  = ie_i;
                    if (reload_zero) st_d.run = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_o  = st_q.cnt;
    assign flag_o = st_q.flag;
    assign irq_o  = st_q.irq;

endmodule

// File: rtl/tick_timer.sv
// System tick down-counter timer, top level
module tick_timer
    import tick_timer_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          DATA_W    = 32,
    parameter int          CNT_W     = 24,
    parameter bit          REF_EN    = 1'b1,
    parameter logic [31:0] CALIB_VAL = 32'd10000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              priv_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              irq_o
);

    typedef struct packed {
        logic [CTRL_WR_BITS-1:0] ctrl;
        logic [CNT_W-1:0]        reload;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic             wr_ctrl, wr_reload, wr_cur, rd_ctrl;
    logic             en_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cur_cnt;
    logic             cnt_flag;
    logic             tick;
    logic             start, stop;
    logic             unused_wdata;

    assign unused_wdata = ^wdata_i[DATA_W-1:CNT_W];

    always_comb begin
        cfg_d = cfg_q;
        if (wr_ctrl)   cfg_d.ctrl   = wdata_i[CTRL_WR_BITS-1:0];
        if (wr_reload) cfg_d.reload = wdata_i[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign en_q     = cfg_q.ctrl[CTRL_EN_BIT];
    assign reload_q = cfg_q.reload;
    assign start    = wr_ctrl &  wdata_i[CTRL_EN_BIT] & ~en_q;
    assign stop     = wr_ctrl & ~wdata_i[CTRL_EN_BIT];

    tick_timer_bus #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .CNT_W     (CNT_W),
        .CALIB_VAL (CALIB_VAL)
    ) u_bus (
        .addr_i      (addr_i),
        .rd_en_i     (rd_en_i),
        .wr_en_i     (wr_en_i),
        .priv_i      (priv_i),
        .ctrl_i      (cfg_q.ctrl),
        .flag_i      (cnt_flag),
        .reload_i    (reload_q),
        .cnt_i       (cur_cnt),
        .wr_ctrl_o   (wr_ctrl),
        .wr_reload_o (wr_reload),
        .wr_cur_o    (wr_cur),
        .rd_ctrl_o   (rd_ctrl),
        .rdata_o     (rdata_o),
        .err_o       (err_o)
    );

    tick_timer_src #(
        .REF_EN (REF_EN)
    ) u_src (
        .en_i       (en_q),
        .core_sel_i (cfg_q.ctrl[CTRL_SRC_BIT]),
        .ref_tick_i (ref_tick_i),
        .tick_o     (tick)
    );

    tick_timer_cnt #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .start_i    (start),
        .stop_i     (stop),
        .clr_i      (wr_cur),
        .flag_clr_i (rd_ctrl),
        .ie_i       (cfg_q.ctrl[CTRL_IE_BIT]),
        .reload_i   (reload_q),
        .cnt_o      (cur_cnt),
        .flag_o     (cnt_flag),
        .irq_o      (irq_o)
    );

endmodule

// File: rtl/tick_timer_chk.sv
// Property checker bound to the timer top
module tick_timer_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic              priv_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              err_o,
    input logic              irq_o,
    input logic              en,
    input logic [CNT_W-1:0]  cnt,
    input logic              flag,
    input logic [CNT_W-1:0]  reload
);

    logic cur_wr;
    assign cur_wr = wr_en_i && priv_i && (addr_i == ADDR_W'(8));

    p_irq_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_irq_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag);

    p_flag_at_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> (cnt == '0));

    p_cur_write_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (cnt == '0) && !flag && !irq_o);

    p_unpriv_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !priv_i) |=> $stable(reload));

    p_err_no_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (rdata_o == '0));

    p_hold_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !cur_wr) |=> $stable(cnt));

endmodule

bind tick_timer tick_timer_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .CNT_W  (CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_i  (addr_i),
    .wr_en_i (wr_en_i),
    .priv_i  (priv_i),
    .rdata_o (rdata_o),
    .err_o   (err_o),
    .irq_o   (irq_o),
    .en      (en_q),
    .cnt     (cur_cnt),
    .flag    (cnt_flag),
    .reload  (reload_q)
);

// File: tb/tb_tick_timer.sv
`timescale 1ns/1ps
module tb_tick_timer;

    localparam logic [7:0] A_CTRL   = 8'h00;
    localparam logic [7:0] A_RELOAD = 8'h04;
    localparam logic [7:0] A_CUR    = 8'h08;
    localparam logic [7:0] A_CALIB  = 8'h0C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic [7:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic        priv = 1'b1;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        err;
    logic        irq;

    int tests = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    tick_timer dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ref_tick_i (ref_tick),
        .addr_i     (addr),
        .wr_en_i    (wr_en),
        .rd_en_i    (rd_en),
        .priv_i     (priv),
        .wdata_i    (wdata),
        .rdata_o    (rdata),
        .err_o      (err),
        .irq_o      (irq)
    );

    // reference tick: high one cycle in three
    initial begin
        int ph = 0;
        forever begin
            @(negedge clk);
            ph = (ph == 2) ? 0 : ph + 1;
            ref_tick = (ph == 0);
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic p,
                          output logic e);
        @(negedge clk);
        addr = a; wdata = d; priv = p; wr_en = 1'b1;
        #1 e = err;
        @(posedge clk);
        #1 wr_en = 1'b0; priv = 1'b1;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        logic e;
        bus_wr(a, d, 1'b1, e);
    endtask

    task automatic bus_rd(input logic [7:0] a, input logic p,
                          output logic [31:0] d, output logic e);
        @(negedge clk);
        addr = a; priv = p; rd_en = 1'b1;
        #1 d = rdata; e = err;
        @(posedge clk);
        #1 rd_en = 1'b0; priv = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        logic e;
        bus_rd(a, 1'b1, d, e);
    endtask

    // count irq-high cycles over n cycles
    task automatic watch(input int n, output int hits);
        hits = 0;
        for (int k = 0; k < n; k++) begin
            @(posedge clk);
            #1 if (irq) hits++;
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, d2;
        logic        e;
        int          hits, first, gap;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 / R2 reset state and map
        chk("R1 irq after reset", {31'd0, irq}, 32'd0);
        rd(A_CTRL, d);   chk("R1 ctrl reset", d, 32'd0);
        rd(A_RELOAD, d); chk("R1 reload reset", d, 32'd0);
        rd(A_CUR, d);    chk("R1 count reset", d, 32'd0);
        rd(A_CALIB, d);  chk("R2 calibration", d, 32'd10000);

        // R4 reload width
        wr(A_RELOAD, 32'hFFAB_CDEF);
        rd(A_RELOAD, d); chk("R4 reload upper bits dropped", d, 32'h00AB_CDEF);

        // R2 unmapped offsets
        bus_rd(8'h10, 1'b1, d, e);
        chk("R2 unmapped read data", d, 32'd0);
        chk("R2 unmapped read err", {31'd0, e}, 32'd0);
        bus_wr(8'h14, 32'h0000_0007, 1'b1, e);
        chk("R2 unmapped write err", {31'd0, e}, 32'd0);
        rd(A_RELOAD, d); chk("R2 unmapped write reload", d, 32'h00AB_CDEF);
        rd(A_CTRL, d);   chk("R2 unmapped write ctrl", d, 32'd0);

        // R11 unprivileged accesses
        bus_wr(A_RELOAD, 32'h55, 1'b0, e);
        chk("R11 unpriv write err", {31'd0, e}, 32'd1);
        rd(A_RELOAD, d); chk("R11 unpriv write no effect", d, 32'h00AB_CDEF);
        bus_rd(A_CALIB, 1'b0, d, e);
        chk("R11 unpriv read err", {31'd0, e}, 32'd1);
        chk("R11 unpriv read data", d, 32'd0);

        // R3 control write mask
        wr(A_CTRL, 32'hFFFF_FFF6);
        rd(A_CTRL, d); chk("R3 ctrl keeps bits 2:0 only", d, 32'h6);
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d); chk("R3 ctrl cleared", d, 32'h0);

        // R5 / R7 sweep on core clock
        for (int n = 1; n <= 8; n++) begin
            wr(A_CTRL, 32'h0);
            wr(A_RELOAD, n);
            wr(A_CUR, 32'h0);
            wr(A_CTRL, 32'h7);
            first = 0;
            for (int k = 1; k <= 40 && first == 0; k++) begin
                @(posedge clk);
                #1 if (irq) first = k;
            end
            chk($sformatf("R5 first expiry reload=%0d", n), first, n + 1);
            @(posedge clk);
            #1 chk("R7 irq one cycle", {31'd0, irq}, 32'd0);
            gap = 1;
            for (int k = 0; k < 40; k++) begin
                @(posedge clk);
                #1 gap++;
                if (irq) break;
            end
            chk($sformatf("R5 period reload=%0d", n), gap, n + 1);
        end

        // R6 sweep on reference tick
        for (int n = 1; n <= 4; n++) begin
            wr(A_CTRL, 32'h0);
            wr(A_RELOAD, n);
            wr(A_CUR, 32'h0);
            wr(A_CTRL, 32'h3);
            for (int k = 0; k < 100; k++) begin
                @(posedge clk);
                #1 if (irq) break;
            end
            gap = 0;
            for (int k = 0; k < 100; k++) begin
                @(posedge clk);
                #1 gap++;
                if (irq) break;
            end
            chk($sformatf("R6 ref period reload=%0d", n), gap, 3 * (n + 1));
        end

        // R8 clear on read
        wr(A_CTRL, 32'h0);
        rd(A_CTRL, d);  chk("R8 flag seen", d, 32'h1_0000);
        rd(A_CTRL, d);  chk("R8 flag cleared by read", d, 32'h0);

        // R7 no request with interrupts off; R11 flag kept on unpriv read
        wr(A_RELOAD, 32'd3);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h5);
        watch(12, hits);
        chk("R7 no irq when disabled", hits, 0);
        wr(A_CTRL, 32'h4);
        bus_rd(A_CTRL, 1'b0, d, e);
        chk("R11 unpriv ctrl read err", {31'd0, e}, 32'd1);
        rd(A_CTRL, d);  chk("R8 R11 flag survives unpriv read", d, 32'h1_0004);
        rd(A_CTRL, d);  chk("R8 second read clear", d, 32'h4);

        // R12 count frozen when disabled
        rd(A_CUR, d);
        repeat (3) @(posedge clk);
        rd(A_CUR, d2);
        chk("R12 count frozen", d2, d);

        // R9 current-value write
        wr(A_RELOAD, 32'd100);
        wr(A_CTRL, 32'h5);
        repeat (10) @(posedge clk);
        wr(A_CUR, 32'hDEAD_BEEF);
        rd(A_CUR, d);   chk("R9 count zeroed", d, 32'd0);
        rd(A_CTRL, d);  chk("R9 flag cleared", d, 32'h5);
        rd(A_CUR, d);   chk("R9 reload then step", d, 32'd99);

        // R10 zero reload halts with enable kept
        wr(A_CTRL, 32'h0);
        wr(A_RELOAD, 32'd2);
        wr(A_CUR, 32'h0);
        wr(A_CTRL, 32'h7);
        wr(A_RELOAD, 32'd0);
        watch(15, hits);
        chk("R10 last expiry irq", hits, 1);
        rd(A_CUR, d);   chk("R10 count at zero", d, 32'd0);
        rd(A_CTRL, d);  chk("R10 enable still set", d, 32'h1_0007);
        watch(10, hits);
        chk("R10 halted no irq", hits, 0);

        // R12 no restart without a 0 to 1 edge
        wr(A_RELOAD, 32'd2);
        wr(A_CTRL, 32'h7);
        watch(10, hits);
        chk("R12 no restart while enabled", hits, 0);
        rd(A_CUR, d);   chk("R12 count stays zero", d, 32'd0);
        wr(A_CTRL, 32'h0);
        wr(A_CTRL, 32'h7);
        watch(10, hits);
        chk("R12 restart on enable edge", {31'd0, hits > 0}, 32'd1);

        finish_run();
    end

endmodule